// File: doc/BRIEF.md
# NAND Sector ECC Syndrome Corrector

This block takes the 24-bit Hamming parity read back from a flash page's spare area and the 24-bit parity that was just computed over the 512-byte data sector. It forms their difference, the syndrome, and classifies it into one of four outcomes:

- the sector is clean;
- a single data bit is wrong, and its byte and bit position are reported;
- only the stored parity itself is damaged;
- the damage cannot be repaired.

A page that was never programmed carries an all-ones parity field, and the caller can ask for that case to be waived.

A pulse on `start` loads the two codes. The classification is registered, and `done` rises on the following cycle. The status and indices then hold until the next `start`.

After classification, the caller can stream the sector bytes through the block in order. A byte counter, cleared by `start`, tracks the position of each byte. When the result says a data bit is correctable, the block inverts that one bit in the matching byte. Every other byte passes through unchanged, one cycle later.

The controller has two states, `CTL_IDLE` and `CTL_REPORT`:

- `CTL_IDLE` moves to `CTL_REPORT` on `start`.
- `CTL_REPORT` stays in `CTL_REPORT` on a new `start`.
- `CTL_REPORT` returns to `CTL_IDLE` when `start` is low.

`done` is high exactly while the controller is in `CTL_REPORT`.

Top module: `nand_ecc_fixer`

## Requirements
- R1: If the syndrome (stored XOR computed) is zero, status is 2'b00 (clean), and both indices read 0.
- R2: If the stored code is 24'hFFFFFF and `waive_erased` is 1, status is 2'b00 whatever the computed code. With `waive_erased` at 0, the same inputs are classified by the normal rules.
- R3: If every syndrome bit pair (bit 2k+1, bit 2k), for k = 0 to 11, holds differing values, status is 2'b01 (data bit corrected). The bit index is {syn[23], syn[21], syn[19]}, MSB first.
- R4: For status 2'b01, the 9-bit byte index is {syn[17], syn[15], syn[13], syn[11], syn[9], syn[7], syn[5], syn[3], syn[1]}, MSB first. The stored and computed codes carry byte d0 in bits 7:0, d1 in bits 15:8 and d2 in bits 23:16. For any status other than 2'b01, both indices read 0.
- R5: If exactly one of the 24 syndrome bits is set, status is 2'b10 (stored code damaged), and streamed data is left unchanged.
- R6: Any other nonzero syndrome gives status 2'b11 (uncorrectable).
- R7: The result is registered on the clock edge that samples `start`, and `done` is high in the cycle that follows. Status and indices hold their values until the next `start`.
- R8: Each streamed byte appears on `out_data` with `out_valid` one cycle after `in_valid`. `start` clears the byte counter, so the next valid byte is byte 0, and the counter wraps after byte 511. When status is 2'b01, the byte whose position equals the byte index has the bit at the bit index inverted.
- R9: Every byte that is not the located byte, and every byte streamed under any status other than 2'b01, passes through unchanged.
- R10: During and after reset, before any `start`: status is 2'b00, `done` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied at the clock edge |
| start | input | 1 | Loads the codes and classifies them; also clears the byte counter |
| stored_code | input | 24 | Parity read back from flash; d0 in bits 7:0 |
| calc_code | input | 24 | Parity computed over the sector |
| waive_erased | input | 1 | Treat an all-ones stored code as clean |
| status | output | 2 | 00 clean, 01 data fixed, 10 code damaged, 11 uncorrectable |
| byte_idx | output | 9 | Byte position of the faulty bit (status 01) |
| bit_idx | output | 3 | Bit position within that byte (status 01) |
| done | output | 1 | High in the cycle after each `start` |
| in_valid | input | 1 | A sector byte is present on `in_data` |
| in_data | input | 8 | Sector byte in |
| out_valid | output | 1 | `out_data` holds a processed byte |
| out_data | output | 8 | Sector byte out, repaired where located |

## Verification
Correctable syndromes are built from chosen positions, including byte 0, byte 511 and bit 7. This catches a swapped or shifted interleave, which would report the wrong index or flip a neighbouring byte, and an off-by-one counter, which would repair the byte after the target.

An all-ones stored code is tried with the waiver on and off. A design that ignored the waiver, or applied it without being asked, would report the wrong class.

Single-bit syndromes at the bottom, middle and top bits are checked, along with syndromes that break just one bit pair. A design that tested the pair pattern or the population count loosely would call a damaged code a data error and corrupt a good byte.

A restart in the middle of a sector checks that the counter really clears. A counter that kept counting would repair the wrong byte on the second pass.

// File: rtl/nef_pkg.sv
package nef_pkg;
    localparam int SECTOR_BYTES = 512;
    localparam int IDX_W        = $clog2(SECTOR_BYTES);
    localparam int DATA_W       = 8;
    localparam int CODE_BYTES   = 3;
    localparam int CODE_W       = CODE_BYTES * DATA_W;
    localparam int PAIRS        = CODE_W / 2;
    localparam int BIT_W        = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_CLEAN      = 2'b00,
        ST_DATA_FIXED = 2'b01,
        ST_CODE_ERR   = 2'b10,
        ST_UNCORR     = 2'b11
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e            status;
        logic [IDX_W-1:0]       byte_idx;
        logic [BIT_W-1:0]       bit_idx;
    } ecc_result_t;
endpackage

// File: rtl/nef_classify.sv
module nef_classify
    import nef_pkg::*;
(
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              waive_erased,
    output ecc_result_t       result
);
    logic [CODE_W-1:0] syn;
    logic [PAIRS-1:0]  odd_bits;
    logic [PAIRS-1:0]  pair_split;
    logic              is_zero;
    logic              is_erased;
    logic              all_split;
    logic              single_bit;

    assign syn = stored_code ^ calc_code;

    // Odd bit of pair p lands in slot p: slots 0..8 form the byte index,
    // slots 9..11 the bit index.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign odd_bits[p]   = syn[2*p+1];
        assign pair_split[p] = syn[2*p+1] ^ syn[2*p];
    end

    assign is_zero    = (syn == '0);
    assign is_erased  = (stored_code == {CODE_W{1'b1}});
    assign all_split  = &pair_split;
    assign single_bit = !is_zero && ((syn & (syn - 1'b1)) == '0);

    always_comb begin
        result = '0;
        if (is_zero || (is_erased && waive_erased)) begin
            result.status = ST_CLEAN;
        end else if (all_split) begin
            result.status   = ST_DATA_FIXED;
            result.byte_idx = odd_bits[IDX_W-1:0];
            result.bit_idx  = odd_bits[PAIRS-1:IDX_W];
        end else if (single_bit) begin
            result.status = ST_CODE_ERR;
        end else begin
            result.status = ST_UNCORR;
        end
    end
endmodule

// File: rtl/nef_ctrl.sv
module nef_ctrl
    import nef_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  ecc_result_t next_res,
    output ecc_result_t res_q,
    output logic        done
);
    typedef enum logic {
        CTL_IDLE,
        CTL_REPORT
    } ctl_state_e;

    ctl_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            CTL_IDLE:   if (start) state_nxt = CTL_REPORT;
            CTL_REPORT: state_nxt = start ? CTL_REPORT : CTL_IDLE;
            default:    state_nxt = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CTL_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     res_q <= '0;
        else if (start) res_q <= next_res;
    end

    assign done = (state == CTL_REPORT);

    p_done_follows_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_done_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(res_q));
    p_idx_zero_unless_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_q.status != ST_DATA_FIXED) |-> (res_q.byte_idx == '0 && res_q.bit_idx == '0));
endmodule

// File: rtl/nef_stream.sv
module nef_stream
    import nef_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  ecc_result_t       res,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [IDX_W-1:0]  pos;
    logic              hit;
    logic [DATA_W-1:0] flip_mask;

    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (start)    pos <= '0;
        else if (in_valid) pos <= pos + 1'b1;
    end

    assign hit       = (res.status == ST_DATA_FIXED) && (pos == res.byte_idx);
    assign flip_mask = hit ? (DATA_W'(1) << res.bit_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data ^ flip_mask;
        end
    end

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_at_most_one_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_data ^ $past(in_data)) <= 1));
    p_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(res.status) != ST_DATA_FIXED) |-> (out_data == $past(in_data)));
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
    import nef_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              waive_erased,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              done,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    ecc_result_t next_res;
    ecc_result_t res_q;

    nef_classify u_classify (
        .stored_code  (stored_code),
        .calc_code    (calc_code),
        .waive_erased (waive_erased),
        .result       (next_res)
    );

    nef_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .next_res (next_res),
        .res_q    (res_q),
        .done     (done)
    );

    nef_stream u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .res       (res_q),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign status   = res_q.status;
    assign byte_idx = res_q.byte_idx;
    assign bit_idx  = res_q.bit_idx;

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!done && !out_valid && status == 2'b00));
endmodule

// File: tb/nand_ecc_fixer_tb.sv
module nand_ecc_fixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        waive_erased = 1'b0;
    logic [1:0]  status;
    logic [8:0]  byte_idx;
    logic [2:0]  bit_idx;
    logic        done;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [7:0]  out_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nand_ecc_fixer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
        .calc_code(calc_code), .waive_erased(waive_erased), .status(status),
        .byte_idx(byte_idx), .bit_idx(bit_idx), .done(done), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Behavioural classification straight from the requirements.
    function automatic void ref_classify(input logic [23:0] st, input logic [23:0] cc,
                                         input logic ign, output int s, output int by,
                                         output int bi);
        logic [23:0] syn;
        bit ok;
        syn = st ^ cc;
        s = 0; by = 0; bi = 0;
        if (syn == 0 || (st == 24'hFFFFFF && ign)) begin
            s = 0;
        end else begin
            ok = 1;
            for (int j = 0; j < 12; j++)
                if (syn[2*j+1] == syn[2*j]) ok = 0;
            if (ok) begin
                s = 1;
                for (int k = 0; k < 9; k++) by += int'(syn[2*k+1]) << k;
                for (int k = 0; k < 3; k++) bi += int'(syn[19+2*k]) << k;
            end else if ($countones(syn) == 1) begin
                s = 2;
            end else begin
                s = 3;
            end
        end
    endfunction

    // Builds a correctable syndrome that points at byte b, bit t.
    function automatic logic [23:0] make_syn(input int b, input int t);
        logic [23:0] v;
        logic [11:0] a;
        a = {t[2:0], b[8:0]};
        v = '0;
        for (int p = 0; p < 12; p++) begin
            v[2*p+1] = a[p];
            v[2*p]   = ~a[p];
        end
        return v;
    endfunction

    // Cycle-by-cycle reference model.
    int   m_status, m_byte, m_bit, m_cnt;
    bit   m_done, m_out_valid;
    logic [7:0] m_out_data, m_in_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 0; m_byte = 0; m_bit = 0; m_cnt = 0;
            m_done = 0; m_out_valid = 0; m_out_data = 0; m_in_prev = 0;
        end else begin
            m_out_valid = in_valid;
            if (in_valid) begin
                m_in_prev  = in_data;
                m_out_data = in_data;
                if (m_status == 1 && m_cnt == m_byte) m_out_data[m_bit] = ~in_data[m_bit];
            end
            m_done = start;
            if (start) begin
                ref_classify(stored_code, calc_code, waive_erased, m_status, m_byte, m_bit);
                m_cnt = 0;
            end else if (in_valid) begin
                m_cnt = (m_cnt + 1) % 512;
            end
        end
    end

    always @(negedge clk) begin
        string stag;
        if (rst_n) begin
            chk(done == m_done, "R7 done", int'(done), int'(m_done));
            case (m_status)
                0: stag = "R1 status";
                1: stag = "R3 status";
                2: stag = "R5 status";
                default: stag = "R6 status";
            endcase
            chk(int'(status) == m_status, stag, int'(status), m_status);
            chk(int'(byte_idx) == m_byte, "R4 byte_idx", int'(byte_idx), m_byte);
            chk(int'(bit_idx) == m_bit, "R3 bit_idx", int'(bit_idx), m_bit);
            chk(out_valid == m_out_valid, "R8 out_valid", int'(out_valid), int'(m_out_valid));
            if (m_out_valid)
                chk(out_data == m_out_data, (m_out_data != m_in_prev) ? "R8 out_data" : "R9 out_data",
                    int'(out_data), int'(m_out_data));
        end
    end

    task automatic do_start(input logic [23:0] st, input logic [23:0] cc, input logic ign);
        @(negedge clk);
        stored_code = st; calc_code = cc; waive_erased = ign; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic stream(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(i * 7 + seed);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input int s, input int by, input int bi);
        chk(int'(status) == s, tag, int'(status), s);
        chk(int'(byte_idx) == by, tag, int'(byte_idx), by);
        chk(int'(bit_idx) == bi, tag, int'(bit_idx), bi);
        chk(done == 1'b1, "R7 done after start", int'(done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(status == 2'b00, "R10 status in reset", int'(status), 0);
        chk(done == 1'b0, "R10 done in reset", int'(done), 0);
        chk(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 2'b00 && !done && !out_valid, "R10 after reset", int'(status), 0);
        stream(4, 3);

        // R1: clean
        do_start(24'h123456, 24'h123456, 1'b0);
        expect_res("R1 clean", 0, 0, 0);

        // R3 / R4: correctable at several positions
        do_start(24'h0F0F0F ^ make_syn(0, 0), 24'h0F0F0F, 1'b0);
        expect_res("R4 byte 0 bit 0", 1, 0, 0);
        stream(6, 11);
        do_start(24'hA5C3E1 ^ make_syn(511, 7), 24'hA5C3E1, 1'b0);
        expect_res("R4 byte 511 bit 7", 1, 511, 7);
        stream(512, 1);
        do_start(24'h000000 ^ make_syn(341, 5), 24'h000000, 1'b0);
        expect_res("R3 byte 341 bit 5", 1, 341, 5);
        do_start(24'h777777 ^ make_syn(300, 2), 24'h777777, 1'b0);
        expect_res("R8 byte 300 bit 2", 1, 300, 2);
        stream(512, 90);
        // R8: restart mid-sector clears the counter
        do_start(24'h010203 ^ make_syn(3, 6), 24'h010203, 1'b0);
        stream(10, 20);
        do_start(24'h010203 ^ make_syn(3, 6), 24'h010203, 1'b0);
        stream(10, 40);
        // R7: back-to-back starts
        @(negedge clk);
        stored_code = make_syn(9, 1); calc_code = '0; start = 1'b1;
        @(negedge clk);
        stored_code = 24'h000100; calc_code = '0;
        @(negedge clk);
        start = 1'b0;
        expect_res("R7 second start wins", 2, 0, 0);

        // R5: single syndrome bit
        do_start(24'h000001 ^ 24'h5A5A5A, 24'h5A5A5A, 1'b0);
        expect_res("R5 bit 0", 2, 0, 0);
        stream(20, 5);
        do_start(24'h002000, 24'h000000, 1'b0);
        expect_res("R5 bit 13", 2, 0, 0);
        do_start(24'h800000, 24'h000000, 1'b0);
        expect_res("R5 bit 23", 2, 0, 0);

        // R6: uncorrectable
        do_start(24'h000003, 24'h000000, 1'b0);
        expect_res("R6 two bits", 3, 0, 0);
        do_start(make_syn(77, 3) ^ 24'h000004, 24'h000000, 1'b0);
        expect_res("R6 one pair broken", 3, 0, 0);
        stream(16, 9);

        // R2: erased stored code
        do_start(24'hFFFFFF, 24'h000000, 1'b1);
        expect_res("R2 waived", 0, 0, 0);
        stream(8, 2);
        do_start(24'hFFFFFF, 24'h000000, 1'b0);
        expect_res("R2 not waived", 3, 0, 0);
        do_start(24'hFFFFFF, 24'hFFFFFF ^ make_syn(12, 4), 1'b0);
        expect_res("R2 not waived correctable", 1, 12, 4);
        do_start(24'hFFFFFF, 24'hFFFFFF ^ make_syn(12, 4), 1'b1);
        expect_res("R2 waived correctable", 0, 0, 0);
        stream(20, 6);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule